// File: doc/BRIEF.md
# Chained TDM Serial Output Stage

This block puts one stereo sample pair onto a time-division-multiplexed serial line that several identical devices share as a daisy chain. Each device in the chain owns two 32-bit slots. When a frame starts, a device first shifts out its own pair of slots. It then passes on whatever arrived on its chain input during that frame, delayed by exactly two slots' worth of bit clocks. The device wired last in the chain therefore leads the frame. The data of the devices further up follows it, pair by pair, in reverse chain order.

The module runs on the bit clock. A one-cycle frame-start pulse marks each frame. Samples narrower than a slot sit at the top of the slot, and the unused low bits are zero. Once the chain's share of the frame has been sent, the line stays low until the next frame-start pulse. The frame length is set by the spacing of those pulses and only has to cover the whole chain.

Top module: `tdm_chain_out`

## Requirements
- R1: While reset is held and from reset release until the first frame-start pulse, `sdata` is 0 whatever `tdm_in` does.
- R2: In the cycle after the clock edge that samples `frame_sync` high, `sdata` carries frame bit 0. Bits 0 to 31 are the left sample's slot and bits 32 to 63 the right sample's slot, each sent MSB first, one bit per clock.
- R3: A sample of `WORD_W` bits fills the top `WORD_W` positions of its 32-bit slot. The remaining `SLOT_W-WORD_W` positions at the end of the slot are sent as 0.
- R4: Frame bit n, for 64 <= n < 64*`N_DEV`, equals the value `tdm_in` held during frame bit n-64, which is a delay of exactly 64 bit clocks.
- R5: Frame bits at 64*`N_DEV` and later, up to the next frame-start pulse, are 0.
- R6: Both samples are captured on the frame-start edge. Changes to `left_sample` and `right_sample` after that edge have no effect on the current frame.
- R7: A frame-start pulse may follow the previous one after 64*`N_DEV` bit clocks or more. A pulse arriving exactly at that spacing begins the new frame's bit 0 without a gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; every register updates on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_sync | input | 1 | One-cycle frame-start pulse |
| left_sample | input | WORD_W | First-channel sample, captured at frame start |
| right_sample | input | WORD_W | Second-channel sample, captured at frame start |
| tdm_in | input | 1 | Serial output of the upstream device in the chain |
| sdata | output | 1 | Chained serial output |

## Verification
Two functions can fall in the same cycle. The last forwarded bit of one frame or its idle tail can meet the reload of the local pair for the next frame, and a sample input can change while the local slots are still being shifted out. The bench provokes the first case with frames whose spacing is exactly the chain length and with longer frames. It provokes the second by inverting both sample inputs a few bits into selected frames. Every bit of every frame is compared with a value computed from the slot arithmetic: local bit, padding, delayed input bit or idle zero. A pass requires both the boundary bit and the first bit of the new frame to match.

// File: rtl/tdmc_pkg.sv
// Shared definitions for the chained TDM output stage.
// Assumes: slot positions are counted from 0 at the first bit after frame start.
package tdmc_pkg;

    // Which source feeds the serial output for a given frame bit
    typedef enum logic [1:0] {
        SRC_LOCAL = 2'd0,
        SRC_FWD   = 2'd1,
        SRC_IDLE  = 2'd2
    } bit_src_e;

    // Classify a frame bit position into its output source
    function automatic bit_src_e classify_bit(input int unsigned pos,
                                              input int unsigned pair_bits,
                                              input int unsigned chain_bits);
        if (pos < pair_bits)
            return SRC_LOCAL;
        else if (pos < chain_bits)
            return SRC_FWD;
        else
            return SRC_IDLE;
    endfunction

endpackage

// File: rtl/tdmc_bit_counter.sv
// Frame bit position counter.
// Counts the frame bit being driven. It restarts at 0 on frame_sync and parks
// at IDLE_POS once the chain's share of the frame is used up.
// Assumes: frame_sync pulses are at least IDLE_POS clocks apart.
module tdmc_bit_counter #(
    parameter int IDLE_POS = 256,
    localparam int CNT_W   = $clog2(IDLE_POS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_sync,
    output logic [CNT_W-1:0] pos_q,
    output logic [CNT_W-1:0] pos_next
);

    localparam logic [CNT_W-1:0] IDLE_V = CNT_W'(IDLE_POS);

    // Next bit position: restart, hold when parked, else advance
    always_comb begin
        if (frame_sync)
            pos_next = '0;
        else if (pos_q == IDLE_V)
            pos_next = IDLE_V;
        else
            pos_next = pos_q + CNT_W'(1);
    end

    // Position register, parked at idle out of reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            pos_q <= IDLE_V;
        else
            pos_q <= pos_next;
    end

    // R7
    frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sync |-> (pos_q >= IDLE_V - CNT_W'(1)));

    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q == IDLE_V && !frame_sync) |=> (pos_q == IDLE_V));

endmodule

// File: rtl/tdmc_pair_shifter.sv
// Local slot-pair shifter.
// Loads both samples, left-aligned and zero-padded into their slots, on load.
// It then shifts one bit per clock. msb_load gives the first bit in the load
// cycle itself.
// Assumes: WORD_W <= SLOT_W.
module tdmc_pair_shifter #(
    parameter int WORD_W = 24,
    parameter int SLOT_W = 32,
    localparam int PAIR_W = 2 * SLOT_W,
    localparam int PAD_W  = SLOT_W - WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] left_word,
    input  logic [WORD_W-1:0] right_word,
    output logic              msb_load,
    output logic              msb_now
);

    logic [PAIR_W-1:0] pair_img;
    logic [PAIR_W-1:0] shreg;

    // Build the padded two-slot image from the samples
    always_comb begin
        pair_img = (PAIR_W'(left_word) << (SLOT_W + PAD_W))
                 | (PAIR_W'(right_word) << PAD_W);
    end

    // Load the image already advanced by one bit, otherwise keep shifting
    always_ff @(posedge clk) begin
        if (!rst_n)
            shreg <= '0;
        else if (load)
            shreg <= pair_img << 1;
        else
            shreg <= shreg << 1;
    end

    assign msb_load = left_word[WORD_W-1];
    assign msb_now  = shreg[PAIR_W-1];

    generate
        if (PAD_W > 0) begin : g_pad_chk
            // R3
            pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                load |=> (shreg[PAD_W:0] == '0));
        end
    endgenerate

endmodule

// File: rtl/tdmc_delay_line.sv
// Fixed serial delay line.
// dout is din as it was DEPTH clocks earlier.
// Assumes: DEPTH >= 1.
module tdmc_delay_line #(
    parameter int DEPTH = 63
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [DEPTH-1:0] taps;

    generate
        if (DEPTH == 1) begin : g_one
            // Single-stage delay
            always_ff @(posedge clk) begin
                if (!rst_n)
                    taps <= '0;
                else
                    taps <= din;
            end
        end else begin : g_many
            // Shift the input into the tap chain
            always_ff @(posedge clk) begin
                if (!rst_n)
                    taps <= '0;
                else
                    taps <= {taps[DEPTH-2:0], din};
            end
        end
    endgenerate

    assign dout = taps[DEPTH-1];

endmodule

// File: rtl/tdm_chain_out.sv
// Chained TDM serial output stage.
// Each frame it sends the local stereo pair in the first two slots. It then
// forwards the upstream serial stream delayed by two slots, and drives zero
// after 2*N_DEV slots until the next frame_sync.
// Assumes: clk is the bit clock; frame_sync is a one-cycle pulse with spacing
// of at least 2*SLOT_W*N_DEV clocks; WORD_W <= SLOT_W; 1 <= N_DEV <= 8.
module tdm_chain_out #(
    parameter int WORD_W = 24,
    parameter int SLOT_W = 32,
    parameter int N_DEV  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_sync,
    input  logic [WORD_W-1:0] left_sample,
    input  logic [WORD_W-1:0] right_sample,
    input  logic              tdm_in,
    output logic              sdata
);
    import tdmc_pkg::*;

    localparam int PAIR_BITS  = 2 * SLOT_W;
    localparam int CHAIN_BITS = PAIR_BITS * N_DEV;
    localparam int CNT_W      = $clog2(CHAIN_BITS + 1);

    logic [CNT_W-1:0] pos_q;
    logic [CNT_W-1:0] pos_next;
    logic             msb_load;
    logic             msb_now;
    logic             fwd_bit;
    bit_src_e         src_sel;
    logic             sdata_d;

    tdmc_bit_counter #(.IDLE_POS(CHAIN_BITS)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_sync (frame_sync),
        .pos_q      (pos_q),
        .pos_next   (pos_next)
    );

    tdmc_pair_shifter #(.WORD_W(WORD_W), .SLOT_W(SLOT_W)) u_pair (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (frame_sync),
        .left_word  (left_sample),
        .right_word (right_sample),
        .msb_load   (msb_load),
        .msb_now    (msb_now)
    );

    generate
        if (N_DEV > 1) begin : g_fwd
            // The registered output adds one clock, so the taps hold one less
            tdmc_delay_line #(.DEPTH(PAIR_BITS - 1)) u_dly (
                .clk   (clk),
                .rst_n (rst_n),
                .din   (tdm_in),
                .dout  (fwd_bit)
            );
        end else begin : g_nofwd
            assign fwd_bit = 1'b0;
        end
    endgenerate

    // Pick the source for the bit about to be driven
    always_comb begin
        src_sel = classify_bit(int'(pos_next), PAIR_BITS, CHAIN_BITS);
        case (src_sel)
            SRC_LOCAL: sdata_d = frame_sync ? msb_load : msb_now;
            SRC_FWD:   sdata_d = fwd_bit;
            default:   sdata_d = 1'b0;
        endcase
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n)
            sdata <= 1'b0;
        else
            sdata <= sdata_d;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !sdata);

    // R5
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q >= CNT_W'(CHAIN_BITS)) |-> !sdata);

    // R2
    msb_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(frame_sync)) |-> (sdata == $past(left_sample[WORD_W-1])));

endmodule

// File: tb/tb_tdm_chain_out.sv
// Sweeps whole frames through a three-device configuration and compares every
// output bit against slot arithmetic.
module tb_tdm_chain_out;

    localparam int WW  = 24;
    localparam int SW  = 32;
    localparam int ND  = 3;
    localparam int PB  = 2 * SW;
    localparam int CB  = PB * ND;
    localparam int UPB = CB - PB;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_sync = 1'b0;
    logic          tdm_in = 1'b0;
    logic [WW-1:0] left_s = '0;
    logic [WW-1:0] right_s = '0;
    logic          sdata;

    int vectors = 0;
    int errors  = 0;
    bit finished = 0;

    logic [WW-1:0]  e_l, e_r;
    logic [UPB-1:0] e_up;
    bit             e_glitch;
    bit             pending = 0;
    int             prev_len = 0;
    logic [31:0]    seed = 32'h1234_5679;

    tdm_chain_out #(.WORD_W(WW), .SLOT_W(SW), .N_DEV(ND)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_sync   (frame_sync),
        .left_sample  (left_s),
        .right_sample (right_s),
        .tdm_in       (tdm_in),
        .sdata        (sdata)
    );

    always #10 clk = ~clk;

    function automatic logic [31:0] next_rand(input logic [31:0] s);
        logic [31:0] x;
        x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    // Expected frame bit n of the frame under check
    function automatic logic exp_bit(input int n);
        int pos;
        if (n < PB) begin
            pos = n % SW;
            if (pos >= WW) return 1'b0;
            return (n < SW) ? e_l[WW-1-pos] : e_r[WW-1-pos];
        end
        if (n < CB) return e_up[n-PB];
        return 1'b0;
    endfunction

    task automatic check_bit(input int n);
        logic  e;
        string tag;
        e = exp_bit(n);
        if (n < PB) tag = ((n % SW) < WW) ? (e_glitch ? "R2 R6" : "R2") : "R3";
        else if (n < CB) tag = "R4";
        else tag = "R5";
        vectors++;
        if (sdata !== e) begin
            errors++;
            $display("FAIL %s frame bit %0d: actual %b expected %b", tag, n, sdata, e);
        end
    endtask

    task automatic check_zero(input string tag);
        vectors++;
        if (sdata !== 1'b0) begin
            errors++;
            $display("FAIL %s idle output: actual %b expected 0", tag, sdata);
        end
    endtask

    // One frame of len clocks; frame bit c-1 is checked at the start of cycle c
    task automatic run_frame(input int len, input logic [WW-1:0] l,
                             input logic [WW-1:0] r, input logic [UPB-1:0] up,
                             input bit glitch);
        for (int c = 0; c < len; c++) begin
            @(negedge clk);
            if (c > 0) check_bit(c - 1);
            else if (pending) check_bit(prev_len - 1);
            if (c == 0) begin
                e_l = l; e_r = r; e_up = up; e_glitch = glitch;
            end
            frame_sync = (c == 0);
            // R6: sample inputs change after the capture edge
            left_s  = (glitch && c >= 5) ? ~l : l;
            right_s = (glitch && c >= 5) ? ~r : r;
            tdm_in  = (c >= 1 && c - 1 < UPB) ? up[c-1] : 1'b0;
        end
        pending  = 1;
        prev_len = len;
    endtask

    task automatic rand_frame(input int len, input bit glitch);
        logic [WW-1:0]  l, r;
        logic [UPB-1:0] up;
        seed = next_rand(seed); l = seed[WW-1:0];
        seed = next_rand(seed); r = seed[WW-1:0];
        for (int k = 0; k < UPB; k += 32) begin
            seed = next_rand(seed);
            up[k +: 32] = seed;
        end
        run_frame(len, l, r, up, glitch);
    endtask

    task automatic finish_run();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            finish_run();
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check_zero("R1");
        rst_n = 1'b1;
        // R1: quiet before the first frame even with upstream activity
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            check_zero("R1");
            tdm_in = k[0];
        end
        // Fixed patterns
        run_frame(CB, {WW{1'b1}}, {WW{1'b1}}, {UPB{1'b1}}, 0);
        run_frame(CB + 8, {(WW/2){2'b10}}, {(WW/2){2'b01}}, {(UPB/2){2'b10}}, 0);
        run_frame(256, 24'h800001, 24'h000001, {1'b1, {(UPB-2){1'b0}}, 1'b1}, 0);
        run_frame(CB, '0, '0, '0, 0);
        // R6: inputs change mid-frame
        run_frame(CB, 24'hA5C3F0, 24'h0F1E2D, {(UPB/8){8'h3C}}, 1);
        // R7: back-to-back frames at minimum spacing and longer ones
        for (int f = 0; f < 12; f++)
            rand_frame((f % 3 == 0) ? CB + 40 : CB, (f % 4) == 1);
        // Last bit of the final frame, then idle tail
        @(negedge clk);
        check_bit(prev_len - 1);
        frame_sync = 1'b0;
        tdm_in = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check_zero("R5");
        end
        finish_run();
    end

endmodule